// File: doc/BRIEF.md
# Interrupt Source Register Bank

This block is the interrupt register set of one unit. It watches 32 raw event lines and keeps four 32-bit registers behind a small memory-mapped read/write port. The first register shows the sampled level of the event lines. The second is a mask that stops events from being recorded. The third records events and is cleared by writing ones. The fourth is an enable that decides which recorded events raise the pending output sent to a top-level aggregator.

Each bit of the recording register is two deep. An event that arrives while the same bit is already pending is queued. One clear then makes the queued occurrence visible, so a full flush takes two all-ones writes. The 32-bit word can serve two engines, one in the lower 16 bits and one in the upper 16 bits. Each engine has its own pending output, and each engine's user-interrupt event sits at bit 0 of its half.

Top module: `irq_source_bank`

## Requirements
- R1: After reset the mask reads 0xFFFFFFFF, the enable reads 0, the identity register reads 0, and pend_o and both engine pending outputs are 0.
- R2: The register offsets are: live status 0x0, mask 0x4, identity 0x8, enable 0xC. Mask and enable read back what was last written. rdata is registered and shows the addressed register one clock after the address is presented. An access with addr[1:0] not equal to 0 writes nothing and reads 0.
- R3: The live status register returns the level of ev_in sampled one clock earlier. Writes to offset 0x0 change nothing.
- R4: A 0-to-1 transition on an event line whose mask bit is 0 sets that identity bit. A masked transition sets nothing, and a line held high records only one occurrence.
- R5: Writing 1 to an identity bit removes one recorded occurrence of that bit. Writing 0 leaves the bit unchanged.
- R6: Each identity bit holds at most two occurrences. After two events, one clear leaves the bit set and a second clear empties it. A third event while two are held is lost.
- R7: When an event and a clear reach the same bit in the same cycle, the bit is set afterwards. Its occurrence count is the old count minus one, plus one.
- R8: pend_o is the OR of (identity AND enable), registered, so it is due one clock after the identity bit changes.
- R9: eng_pend_o[0] reflects bits 15:0 and eng_pend_o[1] reflects bits 31:16 of (identity AND enable), registered like pend_o. Bit 0 and bit 16 are the user-interrupt bits of the two engines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 32 | Raw event lines |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 4 | Byte offset within the set |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pend_o | output | 1 | Unit pending to the aggregator |
| eng_pend_o | output | 2 | Per-engine pending, one per 16-bit half |

## Verification
An event edge is recorded at the first clock that sees it. The register read port returns the state before the clock that captures the address, and the pending outputs trail the identity register by one more clock. The bench drives every stimulus on a falling edge and samples just after the next rising edge. It checks pending only after one idle clock, so each compare falls in the cycle where the result is due. A cycle-level model in the bench counts occurrences per bit and is advanced in the same step that drives the port. A sweep over all 32 bits checks latching, masking, clearing and the engine split.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int OFS_W = 4;

  typedef enum logic [1:0] {
    SEL_LIVE  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_IDENT = 2'd2,
    SEL_ENAB  = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [OFS_W-1:0] ofs);
    return reg_sel_e'(ofs[3:2]);
  endfunction
endpackage

// File: rtl/irq_edge_sense.sv
module irq_edge_sense #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] ev_q;

  always_ff @(posedge clk) begin
    if (rst) ev_q <= '0;
    else     ev_q <= ev_i;
  end

  assign level_o = ev_q;
  assign rise_o  = ev_i & ~ev_q;
endmodule

// File: rtl/irq_ident_bit.sv
module irq_ident_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic vis_o,
  output logic deep_o
);
  // thermometer count: slot0 = at least one, slot1 = two held
  logic slot0, slot1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot0 <= 1'b0;
      slot1 <= 1'b0;
    end else begin
      unique case ({set_i, clr_i})
        2'b10: begin slot1 <= slot0; slot0 <= 1'b1; end
        2'b01: begin slot0 <= slot1; slot1 <= 1'b0; end
        2'b11: slot0 <= 1'b1;
        default: ;
      endcase
    end
  end

  assign vis_o  = slot0;
  assign deep_o = slot1;
endmodule

// File: rtl/irq_pend_tree.sv
module irq_pend_tree #(
  parameter int W      = 32,
  parameter int HALF_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         ident_i,
  input  logic [W-1:0]         en_i,
  output logic                 pend_o,
  output logic [W/HALF_W-1:0]  half_o
);
  localparam int NH = W / HALF_W;

  logic [W-1:0]  hit;
  logic [NH-1:0] half_hit;

  assign hit = ident_i & en_i;

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign half_hit[h] = |hit[h*HALF_W +: HALF_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      half_o <= '0;
    end else begin
      pend_o <= |hit;
      half_o <= half_hit;
    end
  end
endmodule

// File: rtl/irq_source_bank.sv
module irq_source_bank
  import irq_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        ev_in,
  input  logic                     wr_en,
  input  logic [OFS_W-1:0]         addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     pend_o,
  output logic [DATA_W/HALF_W-1:0] eng_pend_o
);
  localparam int NUM_HALF = DATA_W / HALF_W;

  reg_sel_e          sel;
  logic              aligned;
  logic [DATA_W-1:0] live_q, rise, mask_q, en_q;
  logic [DATA_W-1:0] set_vec, clr_vec, ident_vis, ident_deep;
  logic [DATA_W-1:0] rdata_q;

  assign sel     = decode_sel(addr);
  assign aligned = (addr[1:0] == 2'b00);

  irq_edge_sense #(.W(DATA_W)) u_edge (
    .clk(clk), .rst(rst), .ev_i(ev_in), .level_o(live_q), .rise_o(rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      en_q   <= '0;
    end else if (wr_en && aligned) begin
      if (sel == SEL_MASK) mask_q <= wdata;
      if (sel == SEL_ENAB) en_q   <= wdata;
    end
  end

  assign set_vec = rise & ~mask_q;
  assign clr_vec = (wr_en && aligned && sel == SEL_IDENT) ? wdata : '0;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    irq_ident_bit u_bit (
      .clk(clk), .rst(rst), .set_i(set_vec[b]), .clr_i(clr_vec[b]),
      .vis_o(ident_vis[b]), .deep_o(ident_deep[b])
    );
  end

  irq_pend_tree #(.W(DATA_W), .HALF_W(HALF_W)) u_pend (
    .clk(clk), .rst(rst), .ident_i(ident_vis), .en_i(en_q),
    .pend_o(pend_o), .half_o(eng_pend_o)
  );

  always_ff @(posedge clk) begin
    if (rst || !aligned) begin
      rdata_q <= '0;
    end else begin
      unique case (sel)
        SEL_LIVE:  rdata_q <= live_q;
        SEL_MASK:  rdata_q <= mask_q;
        SEL_IDENT: rdata_q <= ident_vis;
        SEL_ENAB:  rdata_q <= en_q;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;

  if (NUM_HALF < 1) begin : g_bad_cfg
    initial $error("HALF_W must not exceed DATA_W");
  end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [DATA_W-1:0]        ev_in,
  input logic [DATA_W-1:0]        level,
  input logic [DATA_W-1:0]        ident,
  input logic [DATA_W-1:0]        deep,
  input logic [DATA_W-1:0]        mask,
  input logic [DATA_W-1:0]        en,
  input logic                     pend_o,
  input logic [DATA_W/HALF_W-1:0] eng_pend_o
);
  localparam int NH = DATA_W / HALF_W;

  // R3
  live_level_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> level == $past(ev_in));

  // R4
  masked_latch_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((ident & ~$past(ident)) & $past(mask)) == '0);

  // R6
  queue_order_chk: assert property (@(posedge clk) disable iff (rst)
    (deep & ~ident) == '0);

  // R8
  unit_pend_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pend_o == |($past(ident) & $past(en)));

  for (genvar h = 0; h < NH; h++) begin : g_half_chk
    // R9
    engine_pend_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> eng_pend_o[h] ==
        |($past(ident[h*HALF_W +: HALF_W]) & $past(en[h*HALF_W +: HALF_W])));
  end
endmodule

bind irq_source_bank irq_bank_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .ev_in(ev_in), .level(live_q), .ident(ident_vis),
  .deep(ident_deep), .mask(mask_q), .en(en_q), .pend_o(pend_o),
  .eng_pend_o(eng_pend_o)
);

// File: tb/sim_irq_source_bank.sv
module sim_irq_source_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ev_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pend_o;
  logic [1:0]  eng_pend_o;

  irq_source_bank u0 (
    .clk(clk), .rst(rst), .ev_in(ev_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pend_o(pend_o), .eng_pend_o(eng_pend_o)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cnt [32];
  logic [31:0] mask_m = '1, en_m = '0, ev_prev = '0, ev_cur = '0;

  function automatic logic [31:0] vis_m();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = (cnt[i] > 0);
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d);
    logic [31:0] setv, clrv;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; ev_in = ev_cur;
    setv = ev_cur & ~ev_prev & ~mask_m;
    clrv = (w && a == 4'h8) ? d : 32'h0;
    for (int i = 0; i < 32; i++) begin
      if (clrv[i] && cnt[i] > 0) cnt[i]--;
      if (setv[i] && cnt[i] < 2) cnt[i]++;
    end
    if (w && a == 4'h4) mask_m = d;
    if (w && a == 4'hC) en_m = d;
    ev_prev = ev_cur;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, a, d);
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
    step(1'b0, a, 32'h0);
    check(tag, rdata, exp);
  endtask

  task automatic pend_check(input string tag);
    logic [31:0] hit;
    step(1'b0, 4'h0, 32'h0);
    hit = vis_m() & en_m;
    check({tag, " pend"}, {31'h0, pend_o}, {31'h0, |hit});
    check({tag, " eng"}, {30'h0, eng_pend_o}, {30'h0, |hit[31:16], |hit[15:0]});
  endtask

  task automatic pulse(input logic [31:0] bits);
    ev_cur = ev_cur | bits;
    step(1'b0, 4'h0, 32'h0);
    ev_cur = ev_cur & ~bits;
    step(1'b0, 4'h0, 32'h0);
  endtask

  task automatic flush();
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired got %h exp %h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) cnt[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_check("R1 mask", 4'h4, 32'hFFFF_FFFF);
    rd_check("R1 enable", 4'hC, 32'h0);
    rd_check("R1 ident", 4'h8, 32'h0);
    pend_check("R1");

    // R2 offsets, readback, unaligned access
    wr(4'h4, 32'hA5A5_0F0F);
    rd_check("R2 mask", 4'h4, 32'hA5A5_0F0F);
    wr(4'hC, 32'h1234_5678);
    rd_check("R2 enable", 4'hC, 32'h1234_5678);
    wr(4'h5, 32'h0);
    rd_check("R2 unaligned write", 4'h4, 32'hA5A5_0F0F);
    rd_check("R2 unaligned read", 4'hD, 32'h0);

    // R3 live status, writes ignored
    wr(4'h4, 32'hFFFF_FFFF);
    ev_cur = 32'h00F0_0F00;
    step(1'b0, 4'h0, 32'h0);
    rd_check("R3 live", 4'h0, 32'h00F0_0F00);
    wr(4'h0, 32'hFFFF_FFFF);
    rd_check("R3 live after write", 4'h0, 32'h00F0_0F00);
    rd_check("R4 masked not latched", 4'h8, 32'h0);
    ev_cur = 32'h0;
    step(1'b0, 4'h0, 32'h0);
    rd_check("R3 live low", 4'h0, 32'h0);

    // R4 R5 R8 R9 sweep over every bit
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b, nb;
      b  = 32'h1 << i;
      nb = 32'h1 << ((i + 1) % 32);
      flush();
      wr(4'h4, ~b);
      wr(4'hC, b);
      pulse(b | nb);
      rd_check("R4 sweep latch", 4'h8, b);
      pend_check("R8 R9 sweep");
      wr(4'h8, ~b);
      rd_check("R5 zero write keeps", 4'h8, b);
      wr(4'h8, b);
      rd_check("R5 one write clears", 4'h8, 32'h0);
      pend_check("R8 after clear");
    end

    // R4 level held records once
    flush();
    wr(4'h4, 32'h0);
    wr(4'hC, 32'h0);
    ev_cur = 32'h0000_0100;
    repeat (4) step(1'b0, 4'h0, 32'h0);
    ev_cur = 32'h0;
    step(1'b0, 4'h0, 32'h0);
    wr(4'h8, 32'h0000_0100);
    rd_check("R4 held level single", 4'h8, 32'h0);

    // R6 two-deep queue
    pulse(32'h8);
    pulse(32'h8);
    wr(4'h8, 32'h8);
    rd_check("R6 second occurrence", 4'h8, 32'h8);
    wr(4'h8, 32'h8);
    rd_check("R6 drained", 4'h8, 32'h0);
    pulse(32'h8); pulse(32'h8); pulse(32'h8);
    wr(4'h8, 32'h8);
    wr(4'h8, 32'h8);
    rd_check("R6 saturates at two", 4'h8, 32'h0);

    // R7 event and clear in the same cycle
    ev_cur = 32'h20;
    wr(4'h8, 32'h20);
    rd_check("R7 empty then collide", 4'h8, 32'h20);
    ev_cur = 32'h0;
    step(1'b0, 4'h0, 32'h0);
    ev_cur = 32'h20;
    wr(4'h8, 32'h20);
    ev_cur = 32'h0;
    step(1'b0, 4'h0, 32'h0);
    wr(4'h8, 32'h20);
    rd_check("R7 count held one", 4'h8, 32'h0);

    // R9 engine split on user-interrupt bits
    flush();
    wr(4'hC, 32'hFFFF_FFFF);
    pulse(32'h0001_0000);
    pend_check("R9 upper engine");
    pulse(32'h0000_0001);
    pend_check("R9 both engines");
    check("R9 eng value", {30'h0, eng_pend_o}, 32'h3);
    flush();
    pend_check("R9 flushed");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule